// File: doc/BRIEF.md
# Raster Display Controller Sequencer and Status Unit

This unit is the register-facing control core of a raster display controller. Software writes a control word that holds the run bit, the panel-type bit, five interrupt enables, the line-flag clear policy and a two-bit fetch-mode field. The unit then steps the fetch datapath through a colour-table fetch, a frame fetch or both in turn. It reports progress and faults in a seven-bit status word. Most status bits have their own clear rule.

The datapath reports colour-table completion, frame completion, vertical sync, bias-count expiry, line match, FIFO underflow and sync loss as single-cycle pulses. The unit turns them into sticky flags and into one level interrupt. It tells the datapath what to fetch through a two-bit mode output. A stop request takes effect gracefully: the fetch in flight runs to its end, and only then does the unit return to idle and raise its completion flag.

Top module: `lcd_ctl_unit`

## Requirements
- R1: After reset the control word (address 0) and the status word (address 1) read zero, `irq` is low and `fetchMode` is 00 (idle).
- R2: A write to address 0 keeps only bit 0 (run), bits 2..6 (interrupt enables), bit 7 (active-matrix panel), bit 10 (line clear policy) and bits 21:20 (fetch mode). All other bits read back as zero. Unused addresses read zero.
- R3: One cycle after the run bit becomes set while idle, the fetch begins. Mode 00 fetches the colour table and then frames. Mode 01 fetches the colour table only and then parks with `fetchMode` 00. Modes 10 and 11 fetch frames only. `fetchMode` is 01 while the colour table is fetched and 10 while frames are fetched.
- R4: A colour-table completion pulse during the table fetch sets status bit 6.
- R5: Clearing the run bit during a frame fetch keeps `fetchMode` at 10 until the next frame completion pulse. At that pulse the unit goes idle and sets status bit 0. A stop while parked completes one cycle after the run bit clears.
- R6: Status bit 0 ignores write-one-to-clear. It clears only on a control write that sets the run bit while the bit was clear.
- R7: Underflow (status bit 5) and sync loss (bit 2) ignore write-one-to-clear. Both clear on a control write that clears a set run bit.
- R8: In mode 01, status bit 6 clears only by writing 1 to it and survives a stop. In the other modes it ignores that write and clears when the run bit is cleared.
- R9: Vertical sync (bit 1) and bias count (bit 3) clear when 1 is written to them.
- R10: With control bit 10 at 0, the line flag (bit 4) clears by writing 1 to it. With control bit 10 at 1, that write is ignored and the flag clears at the next vertical sync pulse.
- R11: `irq` is the OR of: done AND enable bit 3, sync AND enable bit 2, colour table AND enable bit 4, line AND enable bit 6, underflow, and sync loss. The bias flag and enable bit 5 never affect `irq`.
- R12: An event that sets a flag in the same cycle as a clear of that flag leaves the flag set. A run-bit set write that coincides with a stop completion suppresses the done flag.
- R13: Sync, bias, line, underflow and sync-loss pulses are ignored unless a frame fetch is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write word address (0 control, 1 status) |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read word address |
| rdData | output | DATA_W | Read data, combinational |
| evPaletteEnd | input | 1 | Colour-table fetch finished |
| evFrameEnd | input | 1 | Frame fetch finished |
| evVsync | input | 1 | Vertical sync pulse |
| evAcBias | input | 1 | Bias count expired |
| evLine | input | 1 | Line match pulse |
| evUnderflow | input | 1 | Pixel FIFO underflow |
| evSyncLost | input | 1 | Frame sync lost |
| irq | output | 1 | Level interrupt |
| fetchMode | output | 2 | 00 idle, 01 colour table, 10 frame |

## Verification
Two collisions are provoked. In the first, an event pulse and a write-one-to-clear of the same flag fall in one cycle. The randomized phase drives sync, bias and line pulses together with random clear writes every cycle, and a bench model judges the result with set taking priority. In the second, a run-bit set write lands in the very cycle a stop finishes with a frame completion. The check is that the done flag stays clear and a new frame fetch begins one cycle later.

// File: rtl/lcd_ctl_pkg.sv
package lcd_ctl_pkg;

  typedef enum logic [1:0] {
    FETCH_NONE  = 2'b00,
    FETCH_PAL   = 2'b01,
    FETCH_FRAME = 2'b10
  } fetch_e;

  typedef struct packed {
    logic setDone;
    logic setPal;
    logic frameActive;
  } seq_strobe_t;

  localparam int CB_RUN   = 0;
  localparam int CB_IEVS  = 2;
  localparam int CB_IEDN  = 3;
  localparam int CB_IEPAL = 4;
  localparam int CB_IELNN = 5;
  localparam int CB_IELN  = 6;
  localparam int CB_TFT   = 7;
  localparam int CB_LSEL  = 10;
  localparam int CB_MODE  = 20;

  localparam int SB_DONE  = 0;
  localparam int SB_VS    = 1;
  localparam int SB_SLOST = 2;
  localparam int SB_ACB   = 3;
  localparam int SB_LINE  = 4;
  localparam int SB_UF    = 5;
  localparam int SB_PAL   = 6;
  localparam int STAT_W   = 7;

  localparam logic [1:0] MODE_PAL_ONLY = 2'b01;

endpackage

// File: rtl/lcd_ctl_seq.sv
module lcd_ctl_seq
  import lcd_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlEn,
  input  logic [1:0]  loadMode,
  input  logic        evPaletteEnd,
  input  logic        evFrameEnd,
  output seq_strobe_t strobe,
  output logic [1:0]  fetchMode
);

  typedef enum logic [1:0] {S_IDLE, S_PAL, S_HOLD, S_FRAME} state_e;
  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      S_IDLE: if (ctrlEn) stateD = loadMode[1] ? S_FRAME : S_PAL;
      S_PAL: begin
        if (evPaletteEnd) begin
          strobe.setPal = 1'b1;
          if (!ctrlEn) begin
            strobe.setDone = 1'b1;
            stateD = S_IDLE;
          end else if (loadMode == MODE_PAL_ONLY) begin
            stateD = S_HOLD;
          end else begin
            stateD = S_FRAME;
          end
        end
      end
      S_HOLD: begin
        if (!ctrlEn) begin
          strobe.setDone = 1'b1;
          stateD = S_IDLE;
        end
      end
      S_FRAME: begin
        strobe.frameActive = 1'b1;
        if (evFrameEnd && !ctrlEn) begin
          strobe.setDone = 1'b1;
          stateD = S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    case (stateQ)
      S_PAL:   fetchMode = FETCH_PAL;
      S_FRAME: fetchMode = FETCH_FRAME;
      default: fetchMode = FETCH_NONE;
    endcase
  end

  // R5: completion is only reported once the run bit is already clear
  assert_done_needs_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setDone |-> !ctrlEn);

  // R5: a running frame fetch never drops to idle
  assert_frame_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_FRAME && ctrlEn) |=> (stateQ == S_FRAME));

  // R3: the fetch mode output carries a legal code
  assert_fetch_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fetchMode));

endmodule

// File: rtl/lcd_ctl_regs.sv
module lcd_ctl_regs
  import lcd_ctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CTL_ADDR  = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              evVsync,
  input  logic              evAcBias,
  input  logic              evLine,
  input  logic              evUnderflow,
  input  logic              evSyncLost,
  input  seq_strobe_t       strobe,
  output logic              ctrlEn,
  output logic [1:0]        loadMode,
  output logic              doneFlag,
  output logic              irq
);

  localparam logic [DATA_W-1:0] CTL_MASK =
      (DATA_W'(1) << CB_RUN) | (DATA_W'(5'h1F) << CB_IEVS) |
      (DATA_W'(1) << CB_TFT) | (DATA_W'(1) << CB_LSEL) |
      (DATA_W'(3) << CB_MODE);

  logic [DATA_W-1:0] ctrlQ;
  logic [STAT_W-1:0] statQ, statD, setV, clrV;
  logic wrCtl, wrSt, enRise, enFall, act, lineSel;

  assign wrCtl   = wrEn && (wrAddr == ADDR_W'(CTL_ADDR));
  assign wrSt    = wrEn && (wrAddr == ADDR_W'(STAT_ADDR));
  assign enRise  = wrCtl && wrData[CB_RUN] && !ctrlQ[CB_RUN];
  assign enFall  = wrCtl && !wrData[CB_RUN] && ctrlQ[CB_RUN];
  assign act     = strobe.frameActive;
  assign lineSel = ctrlQ[CB_LSEL];

  assign ctrlEn   = ctrlQ[CB_RUN];
  assign loadMode = ctrlQ[CB_MODE+1:CB_MODE];
  assign doneFlag = statQ[SB_DONE];

  always_comb begin
    setV = '0;
    setV[SB_DONE]  = strobe.setDone && !enRise;
    setV[SB_VS]    = act && evVsync;
    setV[SB_SLOST] = act && evSyncLost;
    setV[SB_ACB]   = act && evAcBias;
    setV[SB_LINE]  = act && evLine;
    setV[SB_UF]    = act && evUnderflow;
    setV[SB_PAL]   = strobe.setPal;

    clrV = '0;
    clrV[SB_DONE]  = enRise;
    clrV[SB_VS]    = wrSt && wrData[SB_VS];
    clrV[SB_SLOST] = enFall;
    clrV[SB_ACB]   = wrSt && wrData[SB_ACB];
    clrV[SB_LINE]  = lineSel ? (act && evVsync) : (wrSt && wrData[SB_LINE]);
    clrV[SB_UF]    = enFall;
    clrV[SB_PAL]   = (loadMode == MODE_PAL_ONLY) ? (wrSt && wrData[SB_PAL]) : enFall;

    statD = (statQ & ~clrV) | setV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      statQ <= '0;
    end else begin
      if (wrCtl) ctrlQ <= wrData & CTL_MASK;
      statQ <= statD;
    end
  end

  always_comb begin
    irq = statQ[SB_UF] | statQ[SB_SLOST];
    irq = irq | (statQ[SB_DONE] & ctrlQ[CB_IEDN]);
    irq = irq | (statQ[SB_VS]   & ctrlQ[CB_IEVS]);
    irq = irq | (statQ[SB_PAL]  & ctrlQ[CB_IEPAL]);
    irq = irq | (statQ[SB_LINE] & ctrlQ[CB_IELN]);
  end

  always_comb begin
    if (rdAddr == ADDR_W'(CTL_ADDR))       rdData = ctrlQ;
    else if (rdAddr == ADDR_W'(STAT_ADDR)) rdData = DATA_W'(statQ);
    else                                   rdData = '0;
  end

  // R6: done holds until a run-bit set write
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[SB_DONE] && !(wrCtl && wrData[CB_RUN])) |=> statQ[SB_DONE]);

  // R7: a stop write removes a pending underflow flag
  assert_uf_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && !wrData[CB_RUN] && ctrlQ[CB_RUN] && !(act && evUnderflow))
      |=> !statQ[SB_UF]);

endmodule

// File: rtl/lcd_ctl_unit.sv
module lcd_ctl_unit
  import lcd_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              evPaletteEnd,
  input  logic              evFrameEnd,
  input  logic              evVsync,
  input  logic              evAcBias,
  input  logic              evLine,
  input  logic              evUnderflow,
  input  logic              evSyncLost,
  output logic              irq,
  output logic [1:0]        fetchMode
);

  seq_strobe_t strobe;
  logic        ctrlEn;
  logic [1:0]  loadMode;
  logic        doneFlag;

  lcd_ctl_seq u_seq (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .loadMode(loadMode),
    .evPaletteEnd(evPaletteEnd), .evFrameEnd(evFrameEnd),
    .strobe(strobe), .fetchMode(fetchMode)
  );

  lcd_ctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evVsync(evVsync), .evAcBias(evAcBias),
    .evLine(evLine), .evUnderflow(evUnderflow), .evSyncLost(evSyncLost),
    .strobe(strobe), .ctrlEn(ctrlEn), .loadMode(loadMode),
    .doneFlag(doneFlag), .irq(irq)
  );

  // R5: a raised done flag means the fetch engine is at rest
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> (fetchMode == FETCH_NONE));

endmodule

// File: tb/test_lcd_ctl_unit.sv
module test_lcd_ctl_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic evPaletteEnd = 0, evFrameEnd = 0, evVsync = 0, evAcBias = 0;
  logic evLine = 0, evUnderflow = 0, evSyncLost = 0;
  logic irq;
  logic [1:0] fetchMode;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_ctl_unit i_lcd_ctl_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evPaletteEnd(evPaletteEnd),
    .evFrameEnd(evFrameEnd), .evVsync(evVsync), .evAcBias(evAcBias),
    .evLine(evLine), .evUnderflow(evUnderflow), .evSyncLost(evSyncLost),
    .irq(irq), .fetchMode(fetchMode)
  );

  function automatic logic expIrq(input logic [31:0] c, input logic [6:0] s);
    return (s[0] & c[3]) | (s[1] & c[2]) | (s[6] & c[4]) | (s[4] & c[6]) | s[5] | s[2];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic chkStat(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(1, v);
    chk(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [6:0]  mStat;
    logic [31:0] mCtl;
    void'($urandom(32'd4711));
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    chkStat("R1 status", 0);
    chk("R1 irq", irq, 0);
    chk("R1 fetch", fetchMode, 0);

    // R2 field retention
    wr(0, 32'hFFFF_FFFE);
    rd(0, v); chk("R2 ctrl mask", v, 32'h0030_04FC);
    rd(2, v); chk("R2 unused addr", v, 0);
    wr(0, 0);
    tick();
    chk("R3 idle when stopped", fetchMode, 0);

    // R3/R4 mode 00: table then frame
    wr(0, 32'h0000_0011);
    tick();
    chk("R3 table fetch", fetchMode, 2'b01);
    evPaletteEnd = 1; tick(); evPaletteEnd = 0;
    chk("R3 frame after table", fetchMode, 2'b10);
    chkStat("R4 table flag", 32'h40);
    chk("R11 table irq", irq, 1);
    wr(1, 32'h40);
    chkStat("R8 w1c ignored mode 00", 32'h40);

    // R5 graceful stop, R8 cleared by stop
    wr(0, 32'h0000_0018);
    chkStat("R8 stop clears table flag", 0);
    tick(); tick();
    chk("R5 frame continues", fetchMode, 2'b10);
    evFrameEnd = 1; tick(); evFrameEnd = 0;
    chk("R5 idle after frame", fetchMode, 0);
    chkStat("R5 done set", 32'h01);
    chk("R11 done irq", irq, 1);

    // R6 done stickiness
    wr(1, 32'h01);
    chkStat("R6 w1c ignored", 32'h01);
    wr(0, 32'h0000_0018);
    chkStat("R6 held w/o run", 32'h01);
    wr(0, 32'h0020_0001);
    chkStat("R6 cleared on run", 0);
    tick();
    chk("R3 frame-only", fetchMode, 2'b10);

    // R7 fault flags
    evUnderflow = 1; tick(); evUnderflow = 0;
    chkStat("R7 underflow", 32'h20);
    chk("R11 underflow irq", irq, 1);
    wr(1, 32'h20);
    chkStat("R7 underflow w1c ignored", 32'h20);
    evSyncLost = 1; tick(); evSyncLost = 0;
    chkStat("R7 sync lost", 32'h24);

    // R12 set wins over w1c, R9 w1c
    evVsync = 1; tick(); evVsync = 0;
    evVsync = 1; wr(1, 32'h02); evVsync = 0;
    chkStat("R12 set beats clear", 32'h26);
    wr(1, 32'h02);
    chkStat("R9 vsync w1c", 32'h24);

    // R7 cleared by stop
    wr(0, 32'h0020_0000);
    chkStat("R7 stop clears faults", 0);
    evFrameEnd = 1; tick(); evFrameEnd = 0;
    chkStat("R5 done again", 32'h01);
    chk("R11 done masked", irq, 0);

    // R13 events ignored while idle
    evUnderflow = 1; evLine = 1; tick(); evUnderflow = 0; evLine = 0;
    chkStat("R13 idle ignores events", 32'h01);

    // R12 re-enable collides with stop completion
    wr(0, 32'h0020_0001);
    tick();
    wr(0, 32'h0020_0000);
    evFrameEnd = 1; wr(0, 32'h0020_0001); evFrameEnd = 0;
    chkStat("R12 done suppressed", 0);
    chk("R12 idle at collision", fetchMode, 0);
    tick();
    chk("R12 restarts", fetchMode, 2'b10);

    // R10 line clear policy
    wr(0, 32'h0020_0401);
    evLine = 1; tick(); evLine = 0;
    wr(1, 32'h10);
    chkStat("R10 w1c ignored sel1", 32'h10);
    evVsync = 1; tick(); evVsync = 0;
    chkStat("R10 cleared by vsync", 32'h02);
    wr(1, 32'h02);
    wr(0, 32'h0020_0001);
    evLine = 1; tick(); evLine = 0;
    chkStat("R10 line set sel0", 32'h10);
    wr(1, 32'h10);
    chkStat("R10 w1c sel0", 0);

    // R3/R8 table-only mode
    wr(0, 32'h0020_0000);
    evFrameEnd = 1; tick(); evFrameEnd = 0;
    wr(0, 32'h0010_0001);
    tick();
    chk("R3 table-only fetch", fetchMode, 2'b01);
    evPaletteEnd = 1; tick(); evPaletteEnd = 0;
    chk("R3 parked", fetchMode, 0);
    chkStat("R4 table flag mode 01", 32'h40);
    wr(0, 32'h0010_0000);
    tick();
    chkStat("R8 survives stop mode 01 / R5 done", 32'h41);
    wr(1, 32'h40);
    chkStat("R8 w1c mode 01", 32'h01);

    // random phase: R9 R10 R11 R12
    wr(0, 32'h0020_0001);
    tick();
    mStat = 0;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      logic [31:0] d;
      r = $urandom;
      mCtl = 32'h0020_0001 | (r & 32'h7C);
      wr(0, mCtl);
      evVsync = r[8]; evAcBias = r[9]; evLine = r[10];
      d = {$urandom} & 32'h1A;
      wr(1, d);
      mStat = (mStat & ~d[6:0]) | {2'b00, r[10], r[9], 1'b0, r[8], 1'b0};
      evVsync = 0; evAcBias = 0; evLine = 0;
      chkStat("R9/R12 random status", {25'd0, mStat});
      chk("R11 random irq", irq, expIrq(mCtl, mStat));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule